// File: doc/BRIEF.md
# SPI Target with Buffered Transmit Byte

This block is the target (slave) end of a four-wire SPI link. Its serial pins (select, clock, data in, data out) are brought into the system clock domain through two-flop synchronisers, and clock edges are found there. The system clock must run at least four times faster than the serial clock. Clock polarity and clock phase are plain configuration inputs, so all four SPI modes are available.

On the local side, bytes to be sent enter through a valid/ready stream. They land in a one-byte holding register in front of the transmit shift register. A new byte is accepted only while the holding register is empty, so `tx_ready` is the transmit-empty flag. A producer keeps `tx_valid` and `tx_data` steady until it sees `tx_ready`. The holding byte moves into the shift register at two points: while select is high, or at a byte boundary inside a transfer. While a byte is on the wire, the shift register is locked. Received bytes leave through a valid/ready stream. `rx_valid` is the receive-full flag and holds `rx_data` until `rx_ready` takes it. The serial side cannot be stalled. If a byte completes while the previous one is still unread, the new byte replaces it and `rx_overrun` is raised.

Top module: `spi_tgt`

## Requirements
- R1: After reset, `tx_ready` is 1, `rx_valid` is 0, `rx_overrun` is 0 and `miso_oe` is 0.
- R2: A byte is accepted in a cycle where `tx_valid` and `tx_ready` are both 1, and `tx_ready` is 0 in the next cycle. While select is high, the holding byte moves into the shift register, and `tx_ready` returns to 1.
- R3: With `cpha`=0, once select falls, `miso_oe` is 1 and `miso` carries bit 7 of the loaded byte before any clock edge. Later bits follow MSB first and change on trailing clock edges.
- R4: With `cpha`=1, `miso` changes on the leading clock edge and `mosi` is sampled on the trailing edge, MSB first.
- R5: `cpol`=0 means the clock idles low (the leading edge rises). `cpol`=1 means it idles high (the leading edge falls). Both work with both phases.
- R6: After the eighth sampling edge, `rx_data` holds the received byte, MSB first, and `rx_valid` is 1.
- R7: A handshake (`rx_valid` and `rx_ready`) clears `rx_valid` and `rx_overrun`. A byte that completes while `rx_valid` is 1 and not being read sets `rx_overrun` and replaces `rx_data`.
- R8: A byte written after select has fallen is not sent in the current byte. It is sent in the next transfer.
- R9: If no new byte has been written, the next transfer resends the last byte loaded.
- R10: While select is high, `miso_oe` is 0 and the bit count is held at zero. A partial byte is dropped and produces no `rx_valid`.
- R11: With select held low across bytes, a byte waiting in the holding register is loaded at the byte boundary and goes out as the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| sck | input | 1 | Serial clock from the controller |
| ss_n | input | 1 | Active-low target select |
| mosi | input | 1 | Serial data from the controller |
| miso | output | 1 | Serial data to the controller |
| miso_oe | output | 1 | Output enable for `miso` |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Holding register empty, byte accepted |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received byte waiting |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | 8 | Received byte |
| rx_overrun | output | 1 | A byte was replaced before being read |

## Verification
Some rules are checked by the embedded assertions on every cycle: a select-low shift register changes only at a byte boundary, an accepted write makes the holding register full, the bit count is zero whenever select is high, and the flag rules for reading and overrun hold. The serial behaviour itself can only be shown by the bench's scenarios. These cover the MSB appearing before the first clock edge, the edge on which each mode drives and samples, the byte order, a late write deferred to the next transfer, a resent byte, a dropped partial byte and back-to-back bytes under one select.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
  // serial clock events, already normalised for polarity
  typedef struct packed {
    logic lead;
    logic trail;
  } sck_ev_t;

  function automatic sck_ev_t find_edges(input logic now, input logic prev, input logic pol);
    sck_ev_t e;
    e.lead  = (now ^ pol) & ~(prev ^ pol);
    e.trail = ~(now ^ pol) & (prev ^ pol);
    return e;
  endfunction
endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST;
        else if (i == 0) stg[i] <= d;
        else stg[i] <= stg[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_tgt_rx.sv
module spi_tgt_rx #(
  parameter int DW = 8,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ss_s,
  input  logic          sample_ev,
  input  logic          mosi_s,
  input  logic          rx_ready,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  output logic          rx_overrun,
  output logic [CW-1:0] cnt,
  output logic          byte_done
);
  localparam logic [CW-1:0] LAST = CW'(DW-1);
  logic [DW-1:0] sh;
  logic          rd;

  assign byte_done = sample_ev && !ss_s && (cnt == LAST);
  assign rd = rx_valid && rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sh  <= '0;
    end else if (ss_s) begin
      cnt <= '0;
    end else if (sample_ev) begin
      sh  <= {sh[DW-2:0], mosi_s};
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid   <= 1'b0;
      rx_data    <= '0;
      rx_overrun <= 1'b0;
    end else if (byte_done) begin
      rx_data    <= {sh[DW-2:0], mosi_s};
      rx_valid   <= 1'b1;
      rx_overrun <= (rx_valid && !rx_ready) || (rx_overrun && !rd);
    end else if (rd) begin
      rx_valid   <= 1'b0;
      rx_overrun <= 1'b0;
    end
  end

  // R7
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && byte_done) |=> (rx_overrun && rx_valid));
  // R7
  read_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !byte_done) |=> (!rx_valid && !rx_overrun));
  // R10
  idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_s |=> (cnt == '0));
endmodule

// File: rtl/spi_tgt_tx.sv
module spi_tgt_tx #(
  parameter int DW = 8,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ss_s,
  input  logic          shift_ev,
  input  logic          byte_done,
  input  logic [CW-1:0] cnt,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [DW-1:0] tx_data,
  output logic          miso,
  output logic          miso_oe
);
  logic [DW-1:0] hold, cur;
  logic          hold_full, wrapped, load;
  logic [CW-1:0] oidx, bit_sel;

  assign tx_ready = !hold_full;
  assign load     = hold_full && (ss_s || (shift_ev && wrapped));
  assign bit_sel  = CW'(DW-1) - oidx;
  assign miso     = cur[bit_sel];
  assign miso_oe  = !ss_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= '0;
      hold_full <= 1'b0;
      cur       <= '0;
    end else begin
      if (tx_valid && tx_ready) begin
        hold      <= tx_data;
        hold_full <= 1'b1;
      end else if (load) begin
        hold_full <= 1'b0;
      end
      if (load) cur <= hold;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrapped <= 1'b0;
      oidx    <= '0;
    end else if (ss_s) begin
      wrapped <= 1'b0;
      oidx    <= '0;
    end else begin
      if (byte_done) wrapped <= 1'b1;
      else if (shift_ev) wrapped <= 1'b0;
      if (shift_ev) oidx <= cnt;
    end
  end

  // R8
  lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ss_s && !(shift_ev && wrapped)) |=> $stable(cur));
  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
endmodule

// File: rtl/spi_tgt.sv
module spi_tgt
  import spi_tgt_pkg::*;
#(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          sck,
  input  logic          ss_n,
  input  logic          mosi,
  output logic          miso,
  output logic          miso_oe,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [DW-1:0] tx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [DW-1:0] rx_data,
  output logic          rx_overrun
);
  localparam int CW = $clog2(DW);

  logic [2:0]    pins_s;
  logic          sck_s, ss_s, mosi_s, sck_prev;
  sck_ev_t       ev;
  logic          sample_ev, shift_ev, byte_done;
  logic [CW-1:0] cnt;

  spi_tgt_sync #(.W(3), .STAGES(SYNC_STAGES), .RST(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sck, ss_n, mosi}), .q(pins_s));
  assign {sck_s, ss_s, mosi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= sck_s;
  end

  assign ev        = find_edges(sck_s, sck_prev, cpol);
  assign sample_ev = !ss_s && (cpha ? ev.trail : ev.lead);
  assign shift_ev  = !ss_s && (cpha ? ev.lead : ev.trail);

  spi_tgt_rx #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .ss_s(ss_s), .sample_ev(sample_ev), .mosi_s(mosi_s),
    .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_overrun(rx_overrun), .cnt(cnt), .byte_done(byte_done));

  spi_tgt_tx #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .ss_s(ss_s), .shift_ev(shift_ev), .byte_done(byte_done),
    .cnt(cnt), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .miso(miso), .miso_oe(miso_oe));

  // R5
  one_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_ev && shift_ev));
endmodule

// File: tb/spi_tgt_test.sv
module spi_tgt_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpol = 1'b0, cpha = 1'b0, sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic tx_valid = 1'b0, rx_ready = 1'b0;
  logic [7:0] tx_data = '0;
  logic miso, miso_oe, tx_ready, rx_valid, rx_overrun;
  logic [7:0] rx_data;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_tgt uut (.clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .sck(sck),
    .ss_n(ss_n), .mosi(mosi), .miso(miso), .miso_oe(miso_oe), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_overrun(rx_overrun));

  // {cpol, cpha, byte sent by target, byte sent by controller}
  localparam logic [17:0] VEC [8] = '{
    {1'b0, 1'b0, 8'hA5, 8'h3C}, {1'b0, 1'b1, 8'h81, 8'hE7},
    {1'b1, 1'b0, 8'h5A, 8'h01}, {1'b1, 1'b1, 8'hF0, 8'h80},
    {1'b0, 1'b0, 8'h00, 8'hFF}, {1'b1, 1'b1, 8'h7E, 8'h96},
    {1'b0, 1'b1, 8'hC3, 8'h24}, {1'b1, 1'b0, 8'h18, 8'hDB}};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = b;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic set_mode(input logic p, input logic h);
    @(negedge clk);
    cpol = p; cpha = h; sck = p;
    idle(6);
  endtask

  task automatic sel(input logic lvl);
    @(negedge clk);
    ss_n = lvl;
    idle(lvl ? 6 : HALF);
  endtask

  task automatic xfer(input logic [7:0] mo, input int nbits, output logic [7:0] mi);
    mi = '0;
    for (int i = 0; i < nbits; i++) begin
      if (!cpha) begin
        mosi = mo[7-i];
        idle(HALF);
        mi[7-i] = miso;
        sck = ~cpol;
        idle(HALF);
        sck = cpol;
      end else begin
        sck = ~cpol;
        mosi = mo[7-i];
        idle(HALF);
        mi[7-i] = miso;
        sck = cpol;
        idle(HALF);
      end
    end
    if (!cpha) idle(HALF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] mi, mi2;
    idle(3);
    // R1 reset state
    chk(tx_ready === 1'b1, "R1 tx_ready", tx_ready, 1);
    chk(rx_valid === 1'b0 && rx_overrun === 1'b0, "R1 rx flags", {rx_valid, rx_overrun}, 0);
    chk(miso_oe === 1'b0, "R1 miso_oe", miso_oe, 0);
    rst_n = 1'b1;
    idle(4);

    // table: R3 R4 R5 R6 across all modes
    for (int v = 0; v < 8; v++) begin
      set_mode(VEC[v][17], VEC[v][16]);
      push(VEC[v][15:8]);
      idle(4);
      chk(tx_ready === 1'b1, "R2 holding emptied while idle", tx_ready, 1);
      sel(1'b0);
      xfer(VEC[v][7:0], 8, mi);
      sel(1'b1);
      chk(mi === VEC[v][15:8], "R3/R4/R5 miso byte", mi, VEC[v][15:8]);
      chk(rx_valid === 1'b1 && rx_data === VEC[v][7:0], "R6 received byte", rx_data, VEC[v][7:0]);
      drain();
    end

    // R3: MSB before the first clock edge, mode 0
    set_mode(1'b0, 1'b0);
    push(8'h96);
    idle(4);
    sel(1'b0);
    chk(miso_oe === 1'b1 && miso === 1'b1, "R3 msb before first edge", {miso_oe, miso}, 2'b11);
    // R8: write after select fell waits for the next transfer
    push(8'h4B);
    chk(tx_ready === 1'b0, "R8 holding full during transfer", tx_ready, 0);
    xfer(8'h00, 8, mi);
    sel(1'b1);
    chk(mi === 8'h96, "R8 current byte unchanged", mi, 8'h96);
    drain();
    sel(1'b0);
    xfer(8'h00, 8, mi);
    sel(1'b1);
    chk(mi === 8'h4B, "R8 late byte sent next", mi, 8'h4B);
    drain();
    // R9: no new write, byte resent
    sel(1'b0);
    xfer(8'h00, 8, mi);
    sel(1'b1);
    chk(mi === 8'h4B, "R9 resend last byte", mi, 8'h4B);
    drain();

    // R7: overrun
    set_mode(1'b1, 1'b1);
    sel(1'b0); xfer(8'h01, 8, mi); sel(1'b1);
    sel(1'b0); xfer(8'h80, 8, mi); sel(1'b1);
    chk(rx_overrun === 1'b1 && rx_valid === 1'b1, "R7 overrun set", {rx_overrun, rx_valid}, 2'b11);
    chk(rx_data === 8'h80, "R7 newer byte kept", rx_data, 8'h80);
    drain();
    chk(rx_valid === 1'b0 && rx_overrun === 1'b0, "R7 read clears", {rx_valid, rx_overrun}, 0);

    // R10: partial byte dropped
    sel(1'b0); xfer(8'hFF, 3, mi); sel(1'b1);
    chk(miso_oe === 1'b0, "R10 output disabled", miso_oe, 0);
    chk(rx_valid === 1'b0, "R10 partial not delivered", rx_valid, 0);
    sel(1'b0); xfer(8'hC3, 8, mi); sel(1'b1);
    chk(rx_data === 8'hC3 && rx_valid === 1'b1, "R10 next byte aligned", rx_data, 8'hC3);
    drain();

    // R11: back-to-back bytes under one select, mode 0
    set_mode(1'b0, 1'b0);
    push(8'hA5);
    idle(4);
    sel(1'b0);
    push(8'h5A);
    xfer(8'h11, 8, mi);
    chk(rx_data === 8'h11, "R11 first received", rx_data, 8'h11);
    drain();
    xfer(8'h22, 8, mi2);
    sel(1'b1);
    chk(mi === 8'hA5, "R11 first byte", mi, 8'hA5);
    chk(mi2 === 8'h5A, "R11 boundary load", mi2, 8'h5A);
    chk(tx_ready === 1'b1, "R11 holding emptied", tx_ready, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule